// File: doc/BRIEF.md
# Multi-Strand Issue and Branch Squash Controller

This block sits between the per-strand instruction queues and the execution pipeline of a processor that time-slices four hardware strands over one shared pipeline. Fetch logic pushes instructions into a small queue per strand. Each cycle the block picks one strand with work in round-robin order and sends that strand's oldest instruction into a four-stage pipeline model: select, decode, operand read and execute. Every slot in the model carries an occupancy bit, a valid bit, the strand id and an opaque payload.

When the execute stage flags a mispredicted branch, the block looks only at the strand that branch belongs to. Each younger instruction of that strand still in flight keeps its slot but loses its valid bit, so it drains as a no-op. Instructions of other strands are not touched. In the same cycle the block empties that strand's queue, refuses a push into it and raises a redirect to fetch with the corrected PC. Three counters track issued instructions, instructions that leave execute still valid, and no-ops that leave execute. Once the pipeline has drained, these satisfy squashed = issued − completed.

Top module: `strand_issue_ctrl`

## Requirements
- R1: Each cycle at most one strand issues. The choice is round-robin: the search starts at the strand after the last one granted, and strand 0 is searched first after reset. A strand is eligible when its queue is non-empty and it is not being flushed in that cycle. Some strand issues whenever any strand is eligible.
- R2: An issued instruction enters the select stage (index 0 of `stage_busy`/`stage_valid`) on the next clock edge. It then advances one stage per clock and is in execute (index 3, shown on `ex_strand`/`ex_payload`) three edges later.
- R3: Each strand has a first-in first-out queue of `FIFO_DEPTH` entries, and instructions of a strand issue in push order. `fifo_full[s]` is high when queue s holds `FIFO_DEPTH` entries, and a push into a full queue is discarded. A pop in the same cycle does not make room for that push.
- R4: A misprediction acts when `ex_mispredict` is high while the execute slot is valid. Then every instruction of the same strand in stages 0 to 2 moves on with its valid bit cleared. Its occupancy bit, strand id and payload are kept.
- R5: A misprediction leaves the valid bits of other strands' instructions unchanged. With `ex_mispredict` low, no valid bit is cleared, no redirect is raised and the issue order is unchanged.
- R6: `redirect_valid` is high in the same cycle as an acting misprediction, with `redirect_strand` set to the execute strand and `redirect_pc` set to `ex_target_pc`. `ex_mispredict` on an empty or already-squashed execute slot has no effect.
- R7: In the cycle of an acting misprediction, the mispredicted strand's queue is emptied, a push into that queue is discarded, and that strand is not granted.
- R8: `issued_count` rises by one per issue. `completed_count` rises when a valid instruction leaves execute, and `squashed_count` rises when a squashed slot leaves execute. With the pipeline empty, squashed = issued − completed.
- R9: After a synchronous active-low reset, all queues are empty, all stage slots are unoccupied and invalid, all counters are zero and `redirect_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | NUM_STRANDS | Per-strand push strobe from fetch |
| push_payload | input | NUM_STRANDS*PAYLOAD_W | Per-strand instruction words, strand s at bits s*PAYLOAD_W upward |
| fifo_full | output | NUM_STRANDS | Per-strand queue full |
| ex_mispredict | input | 1 | Execute logic reports the instruction in execute as a mispredicted branch |
| ex_target_pc | input | PC_W | Corrected PC for that branch |
| stage_busy | output | 4 | Slot occupancy per stage, bit 0 select through bit 3 execute |
| stage_valid | output | 4 | Slot valid per stage, same bit order |
| ex_strand | output | log2(NUM_STRANDS) | Strand id in execute |
| ex_payload | output | PAYLOAD_W | Instruction word in execute |
| redirect_valid | output | 1 | Redirect request to fetch |
| redirect_strand | output | log2(NUM_STRANDS) | Strand to redirect |
| redirect_pc | output | PC_W | PC to fetch from |
| issued_count | output | CNT_W | Instructions issued |
| completed_count | output | CNT_W | Valid instructions that left execute |
| squashed_count | output | CNT_W | No-ops that left execute |

## Verification
The bench goes after back-to-back mispredictions in one strand while the other strands keep flowing. A design that squashed by slot position, or that cleared every strand, would drop valid work of other strands and skew the completed count. It also raises `ex_mispredict` on empty and already-squashed execute slots, where a design that failed to qualify the flag would emit a spurious redirect or flush a queue that still holds good instructions. Pushes are driven fast enough to fill the queues and are made in the same cycle as a flush. A design that let a pop free room early, or that kept a wrong-path push, would issue instructions out of the expected order.

// File: rtl/sisc_pkg.sv
// Shared constants for the strand issue controller.
// Assumes a fixed four-stage pipeline model: select, decode, operand, execute.
package sisc_pkg;
    localparam int NUM_STAGES = 4;
    localparam int EXEC_STAGE = NUM_STAGES - 1;
endpackage

// File: rtl/sisc_strand_fifo.sv
// Per-strand instruction queue, first-in first-out.
// Assumes: flush wins over push and pop; a push into a full queue is dropped
// even when a pop happens in the same cycle; pop is only asserted when not empty.
module sisc_strand_fifo #(
    parameter int PW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [PW-1:0] push_data,
    input  logic          pop,
    output logic          empty,
    output logic          full,
    output logic [PW-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] mem_q [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign head    = mem_q[rd_q];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop_ok)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wr_q] <= push_data;
    end

    // R3: a full queue without a pop stays full; the push is not taken.
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);
    // R3: occupancy never passes the depth.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R7: a flush leaves the queue empty on the next cycle.
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/sisc_rr_arbiter.sv
// Round-robin strand picker.
// Assumes: the search starts at the strand after the last grant; after reset
// the last grant is taken as the highest strand so strand 0 is searched first.
module sisc_rr_arbiter #(
    parameter int NS = 4,
    localparam int SW = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] req,
    output logic          gnt_valid,
    output logic [SW-1:0] gnt_id
);
    logic [SW-1:0] last_q;

    // Search for the first requester after the last grant.
    always_comb begin
        int idx;
        gnt_valid = 1'b0;
        gnt_id    = '0;
        for (int k = 1; k <= NS; k++) begin
            idx = (int'(last_q) + k) % NS;
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_id    = SW'(idx);
            end
        end
    end

    // Remember the last granted strand.
    always_ff @(posedge clk) begin
        if (!rst_n)         last_q <= SW'(NS - 1);
        else if (gnt_valid) last_q <= gnt_id;
    end

    // R1: a grant always goes to a requester.
    p_grant_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> req[gnt_id]);
    // R1: no idle cycle while some strand requests.
    p_work_conserving_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> gnt_valid);
endmodule

// File: rtl/sisc_issue_pipe.sv
// Four-stage pipeline model with per-strand squash and event counters.
// Assumes: the mispredict flag refers to the slot now in execute; a squash clears
// valid bits of same-strand slots moving out of stages 0..2, keeping the slots.
module sisc_issue_pipe
    import sisc_pkg::*;
#(
    parameter int NS    = 4,
    parameter int PW    = 16,
    parameter int CNT_W = 16,
    localparam int SW = $clog2(NS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue_valid,
    input  logic [SW-1:0]         issue_strand,
    input  logic [PW-1:0]         issue_payload,
    input  logic                  ex_mispredict,
    output logic                  squash_fire,
    output logic [NUM_STAGES-1:0] stage_busy,
    output logic [NUM_STAGES-1:0] stage_valid,
    output logic [SW-1:0]         ex_strand,
    output logic [PW-1:0]         ex_payload,
    output logic [CNT_W-1:0]      issued_count,
    output logic [CNT_W-1:0]      completed_count,
    output logic [CNT_W-1:0]      squashed_count
);
    logic [NUM_STAGES-1:0] busy_q, valid_q;
    logic [SW-1:0]         strand_q  [NUM_STAGES];
    logic [PW-1:0]         payload_q [NUM_STAGES];
    logic [CNT_W-1:0]      iss_q, comp_q, sq_q;

    assign squash_fire = ex_mispredict && valid_q[EXEC_STAGE];

    // Select stage loads the issued instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q[0]    <= 1'b0;
            valid_q[0]   <= 1'b0;
            strand_q[0]  <= '0;
            payload_q[0] <= '0;
        end else begin
            busy_q[0]    <= issue_valid;
            valid_q[0]   <= issue_valid;
            strand_q[0]  <= issue_strand;
            payload_q[0] <= issue_payload;
        end
    end

    for (genvar g = 1; g < NUM_STAGES; g++) begin : g_stage
        // Advance one stage; a same-strand slot passing a squash loses valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[g]    <= 1'b0;
                valid_q[g]   <= 1'b0;
                strand_q[g]  <= '0;
                payload_q[g] <= '0;
            end else begin
                busy_q[g]    <= busy_q[g-1];
                valid_q[g]   <= valid_q[g-1] &&
                                !(squash_fire && strand_q[g-1] == strand_q[EXEC_STAGE]);
                strand_q[g]  <= strand_q[g-1];
                payload_q[g] <= payload_q[g-1];
            end
        end

        // R4: the slot itself survives a squash.
        p_slot_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
            busy_q[g] == $past(busy_q[g-1]));
    end

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_chk
        // R4: after a squash no valid slot of that strand is left in flight.
        p_squash_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
            squash_fire |=> !(valid_q[g] && strand_q[g] == $past(strand_q[EXEC_STAGE])));
    end

    // Event counters: issue, valid exit, squashed exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q  <= '0;
            comp_q <= '0;
            sq_q   <= '0;
        end else begin
            if (issue_valid) iss_q <= iss_q + 1'b1;
            if (busy_q[EXEC_STAGE] &&  valid_q[EXEC_STAGE]) comp_q <= comp_q + 1'b1;
            if (busy_q[EXEC_STAGE] && !valid_q[EXEC_STAGE]) sq_q   <= sq_q + 1'b1;
        end
    end

    // R8: one exit is counted for every slot leaving execute.
    p_exit_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_q + sq_q) == CNT_W'($past(comp_q) + $past(sq_q) + CNT_W'($past(busy_q[EXEC_STAGE]))));

    assign stage_busy      = busy_q;
    assign stage_valid     = valid_q;
    assign ex_strand       = strand_q[EXEC_STAGE];
    assign ex_payload      = payload_q[EXEC_STAGE];
    assign issued_count    = iss_q;
    assign completed_count = comp_q;
    assign squashed_count  = sq_q;
endmodule

// File: rtl/strand_issue_ctrl.sv
// Strand issue and squash controller, top level.
// Assumes: one push port per strand from fetch; the execute logic judges
// the branch in the execute slot and reports through ex_mispredict.
module strand_issue_ctrl
    import sisc_pkg::*;
#(
    parameter int NUM_STRANDS = 4,
    parameter int FIFO_DEPTH  = 4,
    parameter int PAYLOAD_W   = 16,
    parameter int PC_W        = 32,
    parameter int CNT_W       = 16,
    localparam int SID_W = $clog2(NUM_STRANDS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_STRANDS-1:0]           push_valid,
    input  logic [NUM_STRANDS*PAYLOAD_W-1:0] push_payload,
    output logic [NUM_STRANDS-1:0]           fifo_full,
    input  logic                             ex_mispredict,
    input  logic [PC_W-1:0]                  ex_target_pc,
    output logic [NUM_STAGES-1:0]            stage_busy,
    output logic [NUM_STAGES-1:0]            stage_valid,
    output logic [SID_W-1:0]                 ex_strand,
    output logic [PAYLOAD_W-1:0]             ex_payload,
    output logic                             redirect_valid,
    output logic [SID_W-1:0]                 redirect_strand,
    output logic [PC_W-1:0]                  redirect_pc,
    output logic [CNT_W-1:0]                 issued_count,
    output logic [CNT_W-1:0]                 completed_count,
    output logic [CNT_W-1:0]                 squashed_count
);
    logic [NUM_STRANDS-1:0] flush, pop, req, empty;
    logic [PAYLOAD_W-1:0]   head_w [NUM_STRANDS];
    logic                   gnt_valid, squash_fire;
    logic [SID_W-1:0]       gnt_id;

    for (genvar s = 0; s < NUM_STRANDS; s++) begin : g_strand
        assign flush[s] = squash_fire && (ex_strand == SID_W'(s));
        assign pop[s]   = gnt_valid && (gnt_id == SID_W'(s));
        assign req[s]   = !empty[s] && !flush[s];

        sisc_strand_fifo #(.PW(PAYLOAD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush[s]),
            .push      (push_valid[s]),
            .push_data (push_payload[s*PAYLOAD_W +: PAYLOAD_W]),
            .pop       (pop[s]),
            .empty     (empty[s]),
            .full      (fifo_full[s]),
            .head      (head_w[s])
        );
    end

    sisc_rr_arbiter #(.NS(NUM_STRANDS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .gnt_valid (gnt_valid),
        .gnt_id    (gnt_id)
    );

    sisc_issue_pipe #(.NS(NUM_STRANDS), .PW(PAYLOAD_W), .CNT_W(CNT_W)) u_pipe (
        .clk             (clk),
        .rst_n           (rst_n),
        .issue_valid     (gnt_valid),
        .issue_strand    (gnt_id),
        .issue_payload   (head_w[gnt_id]),
        .ex_mispredict   (ex_mispredict),
        .squash_fire     (squash_fire),
        .stage_busy      (stage_busy),
        .stage_valid     (stage_valid),
        .ex_strand       (ex_strand),
        .ex_payload      (ex_payload),
        .issued_count    (issued_count),
        .completed_count (completed_count),
        .squashed_count  (squashed_count)
    );

    assign redirect_valid  = squash_fire;
    assign redirect_strand = ex_strand;
    assign redirect_pc     = ex_target_pc;

    // R7: the mispredicted strand is never granted in the squash cycle.
    p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !(gnt_valid && gnt_id == ex_strand));
    // R6: no redirect without a valid instruction in execute.
    p_redirect_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_valid[EXEC_STAGE] |-> !redirect_valid);
    // R7: the redirected strand's queue is empty on the next cycle.
    p_redirect_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> empty[$past(redirect_strand)]);
endmodule

// File: tb/sim_strand_issue_ctrl.sv
module sim_strand_issue_ctrl;
    localparam int NS = 4, DEPTH = 4, PW = 16, PCW = 32, CW = 16, NST = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NS-1:0]      push_valid = '0;
    logic [NS*PW-1:0]   push_payload = '0;
    logic [NS-1:0]      fifo_full;
    logic               ex_mispredict = 1'b0;
    logic [PCW-1:0]     ex_target_pc = '0;
    logic [NST-1:0]     stage_busy, stage_valid;
    logic [1:0]         ex_strand, redirect_strand;
    logic [PW-1:0]      ex_payload;
    logic               redirect_valid;
    logic [PCW-1:0]     redirect_pc;
    logic [CW-1:0]      issued_count, completed_count, squashed_count;

    always #4 clk = ~clk;

    strand_issue_ctrl #(.NUM_STRANDS(NS), .FIFO_DEPTH(DEPTH), .PAYLOAD_W(PW),
                        .PC_W(PCW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_payload(push_payload),
        .fifo_full(fifo_full), .ex_mispredict(ex_mispredict), .ex_target_pc(ex_target_pc),
        .stage_busy(stage_busy), .stage_valid(stage_valid), .ex_strand(ex_strand),
        .ex_payload(ex_payload), .redirect_valid(redirect_valid),
        .redirect_strand(redirect_strand), .redirect_pc(redirect_pc),
        .issued_count(issued_count), .completed_count(completed_count),
        .squashed_count(squashed_count)
    );

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [PW-1:0] mq [NS][$];
    bit            mb [NST];
    bit            mv [NST];
    int            ms [NST];
    logic [PW-1:0] mp [NST];
    int            last = NS - 1;
    int            m_iss = 0, m_comp = 0, m_sq = 0;
    int            seq [NS];
    int            push_rate = 0, br_rate = 0;
    bit            mis_en = 1'b0, stray_en = 1'b0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs, compare outputs, advance the model.
    task automatic step();
        logic [NS-1:0]    pv;
        logic [NS*PW-1:0] pp;
        logic [PCW-1:0]   tpc;
        logic [NST-1:0]   eb, ev;
        logic [NS-1:0]    ef;
        bit               mis, fire, granted;
        int               fs, g;
        bit               acc [NS];
        logic [PW-1:0]    ip;
        for (int s = 0; s < NS; s++) begin
            pv[s] = ($urandom_range(99) < push_rate);
            seq[s]++;
            pp[s*PW +: PW] = {2'(s), 13'(seq[s]), ($urandom_range(99) < br_rate) ? 1'b1 : 1'b0};
        end
        mis = mis_en && ((mb[3] && mp[3][0]) || (!mb[3] && stray_en && $urandom_range(3) == 0));
        tpc = $urandom;
        push_valid = pv; push_payload = pp; ex_mispredict = mis; ex_target_pc = tpc;
        #1;
        fire = mis && mb[3] && mv[3];
        fs = ms[3];
        chk("R6 redirect_valid", redirect_valid, fire);
        if (fire) begin
            chk("R6 redirect_strand", redirect_strand, fs);
            chk("R6 redirect_pc", redirect_pc, tpc);
        end
        for (int i = 0; i < NST; i++) begin eb[i] = mb[i]; ev[i] = mv[i]; end
        chk("R2,R7 stage_busy", stage_busy, eb);
        chk("R4,R5 stage_valid", stage_valid, ev);
        if (mb[3]) begin
            chk("R1 issue order ex_strand", ex_strand, ms[3]);
            chk("R3 queue order ex_payload", ex_payload, mp[3]);
        end
        for (int s = 0; s < NS; s++) ef[s] = (mq[s].size() == DEPTH);
        chk("R3 fifo_full", fifo_full, ef);
        chk("R8 issued_count", issued_count, CW'(m_iss));
        chk("R8 completed_count", completed_count, CW'(m_comp));
        chk("R8 squashed_count", squashed_count, CW'(m_sq));
        // Model next state.
        if (mb[3]) begin
            if (mv[3]) m_comp++; else m_sq++;
        end
        for (int i = NST - 1; i > 0; i--) begin
            mb[i] = mb[i-1];
            mv[i] = mv[i-1] && !(fire && ms[i-1] == fs);
            ms[i] = ms[i-1];
            mp[i] = mp[i-1];
        end
        granted = 1'b0; g = 0;
        for (int k = 1; k <= NS; k++) begin
            int idx = (last + k) % NS;
            if (!granted && mq[idx].size() > 0 && !(fire && idx == fs)) begin
                granted = 1'b1; g = idx;
            end
        end
        for (int s = 0; s < NS; s++)
            acc[s] = pv[s] && !(fire && s == fs) && (mq[s].size() < DEPTH);
        if (fire) mq[fs].delete();
        ip = '0;
        if (granted) begin
            ip = mq[g].pop_front();
            last = g;
            m_iss++;
        end
        mb[0] = granted; mv[0] = granted; ms[0] = g; mp[0] = ip;
        for (int s = 0; s < NS; s++) if (acc[s]) mq[s].push_back(pp[s*PW +: PW]);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) step();
    endtask

    initial begin
        for (int i = 0; i < NST; i++) begin mb[i] = 0; mv[i] = 0; ms[i] = 0; mp[i] = '0; end
        for (int s = 0; s < NS; s++) seq[s] = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R9: reset state.
        chk("R9 reset stage_busy", stage_busy, 0);
        chk("R9 reset stage_valid", stage_valid, 0);
        chk("R9 reset fifo_full", fifo_full, 0);
        chk("R9 reset issued", issued_count, 0);
        chk("R9 reset completed", completed_count, 0);
        chk("R9 reset squashed", squashed_count, 0);
        chk("R9 reset redirect", redirect_valid, 0);
        rst_n = 1'b1;
        // R5: branches present but all predicted correctly.
        push_rate = 30; br_rate = 40; mis_en = 0; stray_en = 0;
        run(300);
        // R4 R6 R7: mixed traffic with mispredictions, queues filling.
        push_rate = 60; br_rate = 15; mis_en = 1; stray_en = 1;
        run(2000);
        // Dense mispredictions, stray flags on empty slots.
        push_rate = 90; br_rate = 50;
        run(800);
        // Sparse traffic: issue order across few ready strands.
        push_rate = 10; br_rate = 20;
        run(500);
        // Drain, then R8 balance.
        push_rate = 0;
        run(20);
        chk("R8 drained pipeline empty", stage_busy, 0);
        chk("R8 drained squashed=issued-completed", squashed_count,
            CW'(issued_count - completed_count));
        chk("R8 drained issued total", issued_count, CW'(m_iss));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule